// File: doc/BRIEF.md
# Register-Mapped SPI Master with Timed Busy Flag

This block is a single-byte SPI master that sits behind a small host register port. Software sets up a 16-bit control register to choose the target slave, the bit rate, whether the chip select stays active after the byte, and whether completion raises an interrupt. A write to the 8-bit data register then starts one full-duplex byte. A busy flag in the control register stays set for the whole byte. The byte takes a fixed number of system clocks that depends only on the rate field.

The serial side runs in mode 0. The serial clock idles low and goes high in the second half of each bit. Data leaves on MOSI most significant bit first, and MISO is sampled as the serial clock rises. At completion the received byte becomes readable through the data register, and an optional one-cycle interrupt pulse is raised. The register port takes single-cycle accesses with no back-pressure: a write is accepted on the clock edge where `reg_wr` is high, and reads are combinational on `reg_addr`. Software finds out whether the engine can take a byte by polling the busy flag.

Top module: `spi_mm_master`

## Requirements
- R1: A write to the control register (`reg_addr`=0) stores only bits 15, 14, 11, 10, 9, 8, 1 and 0 (mask 0xCF03). Bit 7 reads back the busy flag and ignores written values. After reset the control register reads 0x0000.
- R2: Bit 15 is the master enable. While it is clear, a data register write (`reg_addr`=1) starts nothing, and a data register read returns 0.
- R3: A data register write while enabled and not busy sets busy (control bit 7) from the next cycle and starts a transfer of the written low byte. A data write while busy is ignored: the running byte and its length are unchanged.
- R4: Busy stays set for exactly 8*(8<<rate) clocks, where rate is control bits 1:0 latched at the start (64, 128, 256 or 512 clocks). Bit 10 is stored but has no effect: the transfer is always 8 bits long.
- R5: The serial clock is low whenever the block is not busy. Each bit lasts one eighth of the byte time, with the serial clock low for the first half of the bit and high for the second half. MOSI carries the byte most significant bit first.
- R6: MISO is sampled on each rising edge of the serial clock, first bit as the most significant. After completion, a data read returns the received byte in bits 7:0, with bits 15:8 as zero.
- R7: A data register read while busy returns 0.
- R8: Control bits 9:8, latched at the start, pick the slave. Codes 0, 1 and 2 drive `cs_n[code]` low for the whole byte. Code 3 drives no chip select, but the byte timing still runs. At most one chip select is ever low.
- R9: With control bit 11 set at the start, the chip select stays low after the byte ends. Without it, the chip select is released when busy clears. A held chip select is released by a control write that clears bit 15 while idle.
- R10: When a byte completes, `irq` pulses high for one cycle, the first cycle with busy clear, only if control bit 14 is set at that moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 16 | Write data; data register uses bits 7:0 |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out, MSB first |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low slave selects |
| irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
The main sweep runs every rate against every slave code, with two transmit and receive byte pairs per combination. Measuring busy length per rate separates the four durations. Distinct MSB and LSB patterns expose bit-order and sampling-edge mistakes, and the code-3 runs show that timing continues with no select driven. The interrupt enable alternates across the sweep, so a pulse that ignores bit 14 or fires at the start shows up. Separate runs cover a disabled master, a write while busy, the hold flag with its release, the control write mask and the unused bit 10.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  localparam logic [15:0] CTRL_WMASK = 16'hCF03;
  localparam int CB_ENABLE = 15;
  localparam int CB_IRQEN  = 14;
  localparam int CB_HOLD   = 11;
  localparam int CB_BUSY   = 7;
  localparam int CB_DEV_LO = 8;
  localparam int CB_RATE_LO = 0;

  typedef logic [1:0] dev_code_t;
  typedef logic [1:0] rate_code_t;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/spi_mm_ctrl_reg.sv
module spi_mm_ctrl_reg
  import spi_mm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [15:0] wdata,
  output logic [15:0] ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata & CTRL_WMASK;
  end
endmodule

// File: rtl/spi_mm_timer.sv
module spi_mm_timer
  import spi_mm_pkg::*;
#(
  parameter int BIT_LOG2 = 3,
  parameter int CNT_W    = BIT_LOG2 + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  rate_code_t       rate_in,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt,
  output rate_code_t       rate_q
);
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;

  // byte time = 8 bits * (2**BIT_LOG2 << rate) clocks
  always_comb begin
    span = (CNT_W+1)'(1) << (BIT_LOG2 + 3 + int'(rate_q));
    last = CNT_W'(span - 1'b1);
  end

  assign done = busy && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      rate_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      rate_q <= rate_in;
    end else if (busy) begin
      if (cnt == last) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter
  import spi_mm_pkg::*;
#(
  parameter int BIT_LOG2 = 3,
  parameter int CNT_W    = BIT_LOG2 + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       tx_in,
  input  logic             busy,
  input  logic             done,
  input  logic [CNT_W-1:0] cnt,
  input  rate_code_t       rate_q,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic [7:0]       rx_byte
);
  logic [7:0]       tx_q;
  logic [7:0]       rx_sh;
  logic [CNT_W-1:0] bit_mask;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] half_m1;
  logic [2:0]       bit_idx;
  logic             sample;
  int               sh;

  always_comb begin
    sh       = BIT_LOG2 + int'(rate_q);
    bit_mask = CNT_W'(((CNT_W+1)'(1) << sh) - 1'b1);
    phase    = cnt & bit_mask;
    half_m1  = bit_mask >> 1;
    bit_idx  = 3'(cnt >> sh);
    sample   = busy && (phase == half_m1);
    sck      = busy && (phase > half_m1);
    mosi     = busy && tx_q[3'd7 - bit_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
    end else begin
      if (start)  tx_q    <= tx_in;
      if (sample) rx_sh   <= {rx_sh[6:0], miso};
      if (done)   rx_byte <= rx_sh;
    end
  end
endmodule

// File: rtl/spi_mm_cs_ctrl.sv
module spi_mm_cs_ctrl
  import spi_mm_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  dev_code_t         dev_in,
  input  logic              hold_in,
  input  logic              busy,
  input  logic              done,
  input  logic              en,
  output logic [NUM_CS-1:0] cs_n
);
  logic      active;
  logic      hold_q;
  dev_code_t dev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hold_q <= 1'b0;
      dev_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      hold_q <= hold_in;
      dev_q  <= dev_in;
    end else if (done) begin
      active <= hold_q;
    end else if (!busy && !en) begin
      active <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    assign cs_n[g] = !(active && (dev_q == 2'(g)));
  end
endmodule

// File: rtl/spi_mm_master.sv
module spi_mm_master
  import spi_mm_pkg::*;
#(
  parameter int BIT_LOG2 = 3,
  parameter int NUM_CS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              irq
);
  localparam int CNT_W = BIT_LOG2 + 6;

  logic [15:0]      ctrl_q;
  logic             master_en;
  logic             busy;
  logic             done;
  logic             start;
  logic [CNT_W-1:0] cnt;
  rate_code_t       xfer_rate;
  logic [7:0]       rx_byte;

  assign master_en = ctrl_q[CB_ENABLE];
  assign start = reg_wr && (reg_addr == SEL_DATA) && master_en && !busy;

  spi_mm_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(reg_wr && (reg_addr == SEL_CTRL)),
    .wdata(reg_wdata), .ctrl_q(ctrl_q)
  );

  spi_mm_timer #(.BIT_LOG2(BIT_LOG2), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rate_in(ctrl_q[CB_RATE_LO +: 2]),
    .busy(busy), .done(done), .cnt(cnt), .rate_q(xfer_rate)
  );

  spi_mm_shifter #(.BIT_LOG2(BIT_LOG2), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_in(reg_wdata[7:0]),
    .busy(busy), .done(done), .cnt(cnt), .rate_q(xfer_rate),
    .miso(miso), .sck(sck), .mosi(mosi), .rx_byte(rx_byte)
  );

  spi_mm_cs_ctrl #(.NUM_CS(NUM_CS)) u_cs (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dev_in(ctrl_q[CB_DEV_LO +: 2]), .hold_in(ctrl_q[CB_HOLD]),
    .busy(busy), .done(done), .en(master_en), .cs_n(cs_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= done && ctrl_q[CB_IRQEN];
  end

  always_comb begin
    if (reg_addr == SEL_CTRL) begin
      reg_rdata = ctrl_q;
      reg_rdata[CB_BUSY] = busy;
    end else if (!master_en || busy) begin
      reg_rdata = '0;
    end else begin
      reg_rdata = {8'h00, rx_byte};
    end
  end
endmodule

// File: rtl/spi_mm_checks.sv
module spi_mm_checks #(
  parameter int BIT_LOG2 = 3,
  parameter int NUM_CS   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [15:0]       reg_rdata,
  input logic              sck,
  input logic [NUM_CS-1:0] cs_n,
  input logic              irq,
  input logic              busy,
  input logic [1:0]        rate_q,
  input logic              en
);
  logic [BIT_LOG2+7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  a_r4_byte_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == ((BIT_LOG2+8)'(1) << (BIT_LOG2 + 3 + int'(rate_q)))));

  a_r3_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr && en));

  a_r10_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $fell(busy));

  a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r5_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  a_r7_busy_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_addr) |-> (reg_rdata == 16'h0000));
endmodule

bind spi_mm_master spi_mm_checks #(.BIT_LOG2(BIT_LOG2), .NUM_CS(NUM_CS)) u_checks (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .sck(sck), .cs_n(cs_n), .irq(irq),
  .busy(busy), .rate_q(xfer_rate), .en(master_en)
);

// File: tb/test_spi_mm_master.sv
`timescale 1ns/1ps
module test_spi_mm_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sck, mosi, miso, irq;
  logic [2:0]  cs_n;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  int ridx = 0;
  logic [7:0] pat = '0;
  logic [7:0] mos = '0;

  always #2 clk = ~clk;

  spi_mm_master i_spi_mm_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  // slave model: presents pattern MSB first, captures MOSI on sck rise
  assign miso = pat[3'd7 - ridx[2:0]];
  always @(posedge sck) begin
    mos = {mos[6:0], mosi};
    ridx = ridx + 1;
  end
  always @(negedge clk) if (irq) irq_cnt = irq_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
    reg_addr = 1'b0;
  endtask

  // runs one byte and checks length, bit order, select and interrupt
  task automatic xfer(input logic [15:0] ctrl, input logic [7:0] tx,
                      input logic [7:0] p, input logic [7:0] extra_tx,
                      input bit poke, input logic [2:0] cs_after);
    logic [15:0] v;
    int n = 0;
    int dev = int'(ctrl[9:8]);
    int exp_len = 8 * (8 << ctrl[1:0]);
    logic [2:0] exp_cs = (dev < 3) ? ~(3'b001 << dev) : 3'b111;
    pat = p; ridx = 0; mos = '0; irq_cnt = 0;
    wr(1'b0, ctrl);
    wr(1'b1, {8'h00, tx});
    forever begin
      rd(1'b0, v);
      if (!v[7] || n > 5000) break;
      if (n == 0) begin
        chk(cs_n == exp_cs, "R8 select during byte", cs_n, exp_cs);
        chk(sck == 1'b0, "R5 sck low at bit start", sck, 0);
        rd(1'b1, v);
        chk(v == 16'h0, "R7 data read while busy", v, 0);
      end
      if (poke && n == 20) begin
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = {8'h00, extra_tx};
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
        n++;
        continue;
      end
      n++;
      @(negedge clk);
    end
    chk(n == exp_len, "R4 busy length", n, exp_len);
    chk(mos == tx, "R5 MOSI byte", mos, tx);
    rd(1'b1, v);
    chk(v == {8'h00, p}, "R6 received byte", v, p);
    repeat (2) @(negedge clk);
    chk(irq_cnt == int'(ctrl[14]), "R10 irq pulses", irq_cnt, ctrl[14]);
    chk(cs_n == cs_after, "R9 select after byte", cs_n, cs_after);
  endtask

  initial begin
    #600000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v);
    chk(v == 16'h0000, "R1 reset control", v, 0);
    chk(cs_n == 3'b111 && sck == 1'b0 && irq == 1'b0, "R8 reset outputs",
        {cs_n, sck, irq}, 5'b11100);

    // R1 write mask, busy bit not writable
    wr(1'b0, 16'hFFFF);
    rd(1'b0, v);
    chk(v == 16'hCF03, "R1 write mask", v, 16'hCF03);
    wr(1'b0, 16'h0000);

    // R2 disabled master ignores data writes, reads 0
    wr(1'b0, 16'h4001);
    wr(1'b1, 16'h00AA);
    rd(1'b0, v);
    chk(v[7] == 1'b0, "R2 no start when disabled", v[7], 0);
    chk(sck == 1'b0 && cs_n == 3'b111, "R2 bus idle when disabled", {sck, cs_n}, 4'b0111);
    rd(1'b1, v);
    chk(v == 16'h0, "R2 data read when disabled", v, 0);

    // main sweep: every rate x every device, two byte pairs
    for (int r = 0; r < 4; r++) begin
      for (int d = 0; d < 4; d++) begin
        for (int k = 0; k < 2; k++) begin
          logic [15:0] c = 16'h8000 | 16'(d << 8) | 16'(r);
          logic [7:0] tx = k ? 8'h81 ^ 8'(r*16+d) : 8'h5A ^ 8'(d*3+r);
          logic [7:0] rx = k ? 8'hC3 ^ 8'(d) : 8'h1E ^ 8'(r<<4);
          if (((r ^ d ^ k) & 1) != 0) c[14] = 1'b1;
          xfer(c, tx, rx, 8'h00, 1'b0, 3'b111);
        end
      end
    end

    // R3 write while busy is ignored
    xfer(16'h8000 | 16'h0001, 8'hA5, 8'h3C, 8'h0F, 1'b1, 3'b111);

    // R4 bit 10 has no effect on length
    xfer(16'h8000 | 16'h0400, 8'h96, 8'h69, 8'h00, 1'b0, 3'b111);

    // R9 hold keeps select low on device 1, then disable releases it
    xfer(16'h8000 | 16'h0800 | 16'h0100, 8'h12, 8'h34, 8'h00, 1'b0, 3'b101);
    xfer(16'h8000 | 16'h0800 | 16'h0100, 8'h56, 8'h78, 8'h00, 1'b0, 3'b101);
    wr(1'b0, 16'h0000);
    @(negedge clk);
    chk(cs_n == 3'b111, "R9 release on disable", cs_n, 3'b111);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule